// File: doc/BRIEF.md
# Ethernet Transmit Control Register

This block holds the 32-bit control word that software uses to steer an Ethernet MAC transmitter, and it runs the small start/stop handshake that the control word implies. A write to the control offset sets the run enable, a graceful halt request, the frame-shaping options (no padding, no CRC, fast back-off, no defer, SQE test mode) and a request to send a pause or other MAC control frame. The shaping options go straight to the transmit engine. The pause request is set by software and cleared by hardware.

The transmit engine asks permission through `tx_go_o` and reports each packet start, each packet end (sent or dropped) and each control-frame end. Clearing the run enable raises `tx_abort_o` at once while a packet is in flight. A halt request only withholds permission for the next packet. Seven event sources (six engine error pulses plus packet completion) latch into sticky flags. Each flag is gated by its enable bit in the control word, and the results are ORed into one interrupt line. Software clears the flags by writing ones to a separate status offset.

Top module: `eth_tx_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x08) and the status word (offset 0x0C) both read 0, and `irq_o`, `tx_go_o`, `tx_abort_o` and `busy_o` are 0.
- R2: Bit 0 is the run enable. When it is set and bit 1 is clear, `tx_go_o` is 1. If bit 0 is cleared while `busy_o` is 1, `tx_abort_o` is 1 from the cycle after the write until the engine reports the packet dropped.
- R3: Bit 1 is the halt request. While it is set, `tx_go_o` is 0. A packet already in flight continues without abort, and `halted_o` becomes 1 once that packet is done.
- R4: Bit 6 is the pause request and drives `pause_req_o`. Writing a 1 sets it. A `ctl_done_i` pulse clears it. Writing a 0 leaves it unchanged. A write of 1 in the same cycle as `ctl_done_i` leaves it set.
- R5: Control bits 2, 3, 4, 5 and 7 appear on `no_pad_o`, `no_crc_o`, `fast_bo_o`, `no_defer_o` and `sqe_test_o` respectively.
- R6: Control bits 31:15 always read 0. Writes to any offset other than 0x08 or 0x0C change no state.
- R7: A pulse on `evt_i[k]` (k = 0 underrun, 1 deferral, 2 no carrier, 3 excessive collision, 4 late collision, 5 FIFO parity) sets status bit 8+k. `pkt_done_i` or `pkt_drop_i` sets status bit 14 (completion). A write to 0x0C clears each flag whose data bit is 1. An event in the same cycle as its clear leaves the flag set.
- R8: `irq_o` is 1 exactly when some status bit 8..14 is set and control bit of the same position is set.
- R9: `busy_o` becomes 1 after `pkt_start_i` while `tx_go_o` is 1, and becomes 0 after `pkt_done_i` or `pkt_drop_i`. A start and a done in the same cycle keep `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pkt_start_i | input | 1 | Engine starts a packet |
| pkt_done_i | input | 1 | Engine finished a packet |
| pkt_drop_i | input | 1 | Engine discarded a packet |
| ctl_done_i | input | 1 | Engine finished a control frame |
| evt_i | input | 6 | Engine error event pulses |
| tx_go_o | output | 1 | Permission to start a new packet |
| tx_abort_o | output | 1 | Stop the packet in flight now |
| busy_o | output | 1 | A packet is in flight |
| halted_o | output | 1 | Idle and not allowed to start |
| pause_req_o | output | 1 | Send a control frame |
| no_pad_o | output | 1 | Suppress padding |
| no_crc_o | output | 1 | Suppress CRC |
| fast_bo_o | output | 1 | Short back-off for test |
| no_defer_o | output | 1 | Defer counter disabled |
| sqe_test_o | output | 1 | SQE test mode |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two same-cycle collisions exist. A software write of 1 to the pause bit can land on the same edge as the engine's control-frame-done pulse, and an error event can land on the same edge as the status clear for its own flag. The bench drives each pair on a single edge. In both cases it expects the request or the flag to survive, and it checks this by reading the register back and watching the output pin. It then applies the clearing source alone and confirms that the bit falls.

// File: rtl/eth_tx_ctrl_pkg.sv
package eth_tx_ctrl_pkg;
  localparam int DATA_W  = 32;
  localparam int N_EVT   = 7;   // six engine errors plus completion
  localparam int EVT_LSB = 8;

  typedef struct packed {
    logic [16:0] rsvd;
    logic        ie_comp;
    logic        ie_par;
    logic        ie_late;
    logic        ie_excol;
    logic        ie_ncarr;
    logic        ie_defer;
    logic        ie_under;
    logic        sqe;
    logic        pause;
    logic        no_def;
    logic        fast_bo;
    logic        no_crc;
    logic        no_pad;
    logic        halt;
    logic        en;
  } tx_ctrl_t;
endpackage

// File: rtl/eth_tx_ctrl_reg.sv
module eth_tx_ctrl_reg
  import eth_tx_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctl_done_i,
  output tx_ctrl_t          ctrl_o
);
  tx_ctrl_t wr_v, nxt;

  always_comb begin
    wr_v = tx_ctrl_t'(wdata_i);
    nxt  = ctrl_o;
    if (wr_i) begin
      nxt       = wr_v;
      // software can only set the pause request; set beats hardware clear
      nxt.pause = wr_v.pause | (ctrl_o.pause & ~ctl_done_i);
    end else if (ctl_done_i) begin
      nxt.pause = 1'b0;
    end
    nxt.rsvd = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= nxt;
  end
endmodule

// File: rtl/eth_tx_ctrl_seq.sv
module eth_tx_ctrl_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halt_i,
  input  logic pkt_start_i,
  input  logic pkt_done_i,
  input  logic pkt_drop_i,
  output logic go_o,
  output logic abort_o,
  output logic busy_o,
  output logic halted_o
);
  logic busy_q, busy_d, fin;

  assign fin    = pkt_done_i | pkt_drop_i;
  assign go_o   = en_i & ~halt_i;
  // start in the same cycle as a finish keeps the packet slot occupied
  assign busy_d = (busy_q & ~fin) | (pkt_start_i & go_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign busy_o   = busy_q;
  assign abort_o  = busy_q & ~en_i;
  assign halted_o = ~busy_q & ~go_o;
endmodule

// File: rtl/eth_tx_ctrl_irq.sv
module eth_tx_ctrl_irq #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_bits_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[k] <= 1'b0;
      else         flags_o[k] <= evt_i[k] | (flags_o[k] & ~(clr_i & clr_bits_i[k]));
    end
  end

  assign irq_o = |(flags_o & mask_i);
endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_ctrl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pkt_start_i,
  input  logic              pkt_done_i,
  input  logic              pkt_drop_i,
  input  logic              ctl_done_i,
  input  logic [N_EVT-2:0]  evt_i,
  output logic              tx_go_o,
  output logic              tx_abort_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              pause_req_o,
  output logic              no_pad_o,
  output logic              no_crc_o,
  output logic              fast_bo_o,
  output logic              no_defer_o,
  output logic              sqe_test_o,
  output logic              irq_o
);
  localparam int EVT_MSB = EVT_LSB + N_EVT - 1;

  tx_ctrl_t         ctrl_q;
  logic             wr_ctrl, wr_stat;
  logic [N_EVT-1:0] evt_all, flags, mask;

  assign wr_ctrl = wr_en_i && (addr_i == CTRL_OFS);
  assign wr_stat = wr_en_i && (addr_i == STAT_OFS);

  eth_tx_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ctrl),
    .wdata_i    (wdata_i),
    .ctl_done_i (ctl_done_i),
    .ctrl_o     (ctrl_q)
  );

  eth_tx_ctrl_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_q.en),
    .halt_i      (ctrl_q.halt),
    .pkt_start_i (pkt_start_i),
    .pkt_done_i  (pkt_done_i),
    .pkt_drop_i  (pkt_drop_i),
    .go_o        (tx_go_o),
    .abort_o     (tx_abort_o),
    .busy_o      (busy_o),
    .halted_o    (halted_o)
  );

  assign evt_all = {pkt_done_i | pkt_drop_i, evt_i};
  assign mask    = {ctrl_q.ie_comp, ctrl_q.ie_par, ctrl_q.ie_late, ctrl_q.ie_excol,
                    ctrl_q.ie_ncarr, ctrl_q.ie_defer, ctrl_q.ie_under};

  eth_tx_ctrl_irq #(.N(N_EVT)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_all),
    .clr_i      (wr_stat),
    .clr_bits_i (wdata_i[EVT_MSB:EVT_LSB]),
    .mask_i     (mask),
    .flags_o    (flags),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS)      rdata_o = ctrl_q;
    else if (addr_i == STAT_OFS) rdata_o[EVT_MSB:EVT_LSB] = flags;
  end

  assign pause_req_o = ctrl_q.pause;
  assign no_pad_o    = ctrl_q.no_pad;
  assign no_crc_o    = ctrl_q.no_crc;
  assign fast_bo_o   = ctrl_q.fast_bo;
  assign no_defer_o  = ctrl_q.no_def;
  assign sqe_test_o  = ctrl_q.sqe;
endmodule

// File: rtl/eth_tx_ctrl_chk.sv
module eth_tx_ctrl_chk #(
  parameter int N = 7,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              ctl_done_i,
  input logic              pkt_start_i,
  input logic              pkt_done_i,
  input logic              pkt_drop_i,
  input logic              tx_go_o,
  input logic              tx_abort_o,
  input logic              busy_o,
  input logic              pause_req_o,
  input logic              irq_o,
  input logic              en,
  input logic              halt,
  input logic [N-1:0]      flags,
  input logic [N-1:0]      mask
);
  logic pause_set;
  assign pause_set = wr_en_i && (addr_i == CTRL_OFS) && wdata_i[6];

  assert_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en) |-> tx_abort_o);
  assert_halt_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> !tx_go_o);
  assert_pause_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_done_i && !pause_set) |=> !pause_req_o);
  assert_pause_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && !ctl_done_i) |=> pause_req_o);
  assert_comp_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i || pkt_drop_i) |=> flags[N-1]);
  assert_irq_comp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pkt_done_i || pkt_drop_i) && mask[N-1] && !(wr_en_i && addr_i == CTRL_OFS)) |=> irq_o);
  assert_busy_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_start_i && tx_go_o) |=> busy_o);
endmodule

bind eth_tx_ctrl eth_tx_ctrl_chk #(.N(eth_tx_ctrl_pkg::N_EVT), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .ctl_done_i  (ctl_done_i),
  .pkt_start_i (pkt_start_i),
  .pkt_done_i  (pkt_done_i),
  .pkt_drop_i  (pkt_drop_i),
  .tx_go_o     (tx_go_o),
  .tx_abort_o  (tx_abort_o),
  .busy_o      (busy_o),
  .pause_req_o (pause_req_o),
  .irq_o       (irq_o),
  .en          (ctrl_q.en),
  .halt        (ctrl_q.halt),
  .flags       (flags),
  .mask        (mask)
);

// File: tb/eth_tx_ctrl_bench.sv
module eth_tx_ctrl_bench;
  localparam logic [7:0] CTRL = 8'h08;
  localparam logic [7:0] STAT = 8'h0C;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        pkt_start_i = 1'b0, pkt_done_i = 1'b0, pkt_drop_i = 1'b0, ctl_done_i = 1'b0;
  logic [5:0]  evt_i = '0;
  logic        tx_go_o, tx_abort_o, busy_o, halted_o, pause_req_o;
  logic        no_pad_o, no_crc_o, fast_bo_o, no_defer_o, sqe_test_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  eth_tx_ctrl u_eth_tx_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  // one-cycle write; returns at the following negedge with state updated
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(STAT, d); chk("R1 stat", d, 0);
    chk("R1 outs", {irq_o, tx_go_o, tx_abort_o, busy_o}, 4'b0000);
  endtask

  task automatic t_passthru;
    logic [31:0] d;
    wr(CTRL, 32'h0000_00BC);
    chk("R5 pins", {sqe_test_o, no_defer_o, fast_bo_o, no_crc_o, no_pad_o}, 5'b11111);
    wr(CTRL, 32'h0000_0014);
    chk("R5 pins2", {sqe_test_o, no_defer_o, fast_bo_o, no_crc_o, no_pad_o}, 5'b00101);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(CTRL, 32'hFFFF_FFBF);
    rd(CTRL, d); chk("R6 rsvd zero", d, 32'h0000_7FBF);
    wr(8'h10, 32'h0);
    wr(8'h09, 32'h0);
    rd(CTRL, d); chk("R6 other addr ignored", d, 32'h0000_7FBF);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_enable_abort;
    logic [31:0] d;
    wr(STAT, 32'h7F00);
    wr(CTRL, 32'h1);
    chk("R2 go", tx_go_o, 1'b1);
    pulse(pkt_start_i);
    chk("R9 busy", busy_o, 1'b1);
    wr(CTRL, 32'h0);
    chk("R2 abort", {tx_abort_o, tx_go_o, busy_o}, 3'b101);
    pulse(pkt_drop_i);
    chk("R2 abort ends", {tx_abort_o, busy_o, halted_o}, 3'b001);
    rd(STAT, d); chk("R7 drop completes", d, 32'h4000);
  endtask

  task automatic t_halt;
    wr(CTRL, 32'h1);
    pulse(pkt_start_i);
    wr(CTRL, 32'h3);
    chk("R3 halt", {tx_go_o, tx_abort_o, busy_o, halted_o}, 4'b0010);
    pulse(pkt_done_i);
    chk("R3 halted", {busy_o, halted_o}, 2'b01);
    pulse(pkt_start_i);
    chk("R3 no start", busy_o, 1'b0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_b2b;
    wr(CTRL, 32'h1);
    pulse(pkt_start_i);
    @(negedge clk_i); pkt_start_i = 1'b1; pkt_done_i = 1'b1;
    @(negedge clk_i); pkt_start_i = 1'b0; pkt_done_i = 1'b0;
    chk("R9 back to back", busy_o, 1'b1);
    pulse(pkt_done_i);
    chk("R9 idle", busy_o, 1'b0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_pause;
    logic [31:0] d;
    wr(CTRL, 32'h40);
    chk("R4 set", pause_req_o, 1'b1);
    wr(CTRL, 32'h0);
    rd(CTRL, d); chk("R4 write0 ignored", d, 32'h40);
    pulse(ctl_done_i);
    chk("R4 hw clear", pause_req_o, 1'b0);
    wr(CTRL, 32'h40);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = CTRL; wdata_i = 32'h40; ctl_done_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0; ctl_done_i = 1'b0;
    chk("R4 set beats clear", pause_req_o, 1'b1);
    pulse(ctl_done_i);
    rd(CTRL, d); chk("R4 cleared readback", d, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(STAT, 32'h7F00);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i); evt_i = 6'(1 << k);
      @(negedge clk_i); evt_i = '0;
      rd(STAT, d); chk("R7 event bit", d, 32'h100 << k);
      wr(STAT, 32'h100 << k);
    end
    @(negedge clk_i);
    evt_i = 6'h01; wr_en_i = 1'b1; addr_i = STAT; wdata_i = 32'h100;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; wdata_i = '0;
    rd(STAT, d); chk("R7 event beats clear", d, 32'h100);
    wr(STAT, 32'h100);
    rd(STAT, d); chk("R7 w1c", d, 32'h0);
  endtask

  task automatic t_irq;
    @(negedge clk_i); evt_i = 6'h08;
    @(negedge clk_i); evt_i = '0;
    chk("R8 masked", irq_o, 1'b0);
    wr(CTRL, 32'h0000_0800);
    chk("R8 enabled", irq_o, 1'b1);
    wr(CTRL, 32'h0000_4000);
    chk("R8 other mask", irq_o, 1'b0);
    pulse(pkt_done_i);
    chk("R8 completion irq", irq_o, 1'b1);
    wr(STAT, 32'h4000);
    chk("R8 cleared", irq_o, 1'b0);
    wr(STAT, 32'h7F00);
    wr(CTRL, 32'h0);
  endtask

  initial begin
    #1.5;
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_passthru();
    t_reserved();
    t_enable_abort();
    t_halt();
    t_b2b();
    t_pause();
    t_events();
    t_irq();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule